// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns stereo sample pairs into a two-channel serial audio stream. Software writes a left sample and then a right sample through two write strobes that share one data bus; the right write commits the pair into an eight-entry transmit queue. Each strobe on `bit_tick` marks one bit-clock period. On each tick the block drives one bit slot of a 64-slot frame: 32 slots for the left word while `frame_clk` is low, then 32 slots for the right word while it is high. Words leave most significant bit first.

Three framings are selectable. In left-justified framing the MSB sits in the first slot of each half. In one-bit-delay framing the MSB is moved one slot later, so the last data slot of a half-frame spills into the first slot of the next half. In right-justified framing the LSB lands in the last slot of the half. The word length is 16, 24 or 32 bits, taken from the low bits of each sample. If the queue is empty when a new frame must start, the block sends a silent frame and can raise an underflow interrupt. A second interrupt reports a low queue level, using either a half-empty or an empty threshold. Dropping `tx_en` resets the serializer without touching the queue, so software can refill the queue before re-enabling. Transmission then restarts on a clean left-word boundary.

Top module: `aud_tx_serializer`

## Requirements
- R1: After reset `sdata`, `frame_clk`, `fifo_full` and `irq_urun` are 0, and `irq_fifo` is 1 because the queue is empty.
- R2: A `wr_left` strobe stores `wdata` as the pending left sample. A `wr_right` strobe pushes the pair {latest pending left, `wdata`} into the queue. A left strobe alone pushes nothing, and a right strobe while the queue is full is dropped.
- R3: The queue holds 8 pairs and drains in first-in first-out order, one pair per frame. `fifo_full` is 1 exactly when 8 pairs are held.
- R4: Counting ticks from enable as slots n = 0, 1, 2, …, the values driven for slot n are visible from the tick's clock edge onward. `frame_clk` equals bit 5 of (n mod 64), so it is 0 for the left half and 1 for the right half. Outputs change only on a tick or when the block is disabled.
- R5: With `delay_one`=0 and `right_just`=0, slot p of a half (p = 0…31) carries word bit W-1-p for p < W, where W is the word length.
- R6: With `delay_one`=1, all data moves one slot later: slot 0 of a half carries what slot 31 of the previous half would carry, and the next pair is taken at frame slot 1.
- R7: With `right_just`=1, slot p of a half carries word bit 31-p for p >= 32-W, so the LSB sits in the last slot of the half.
- R8: `word_len` code 0 selects 16 bits, 1 selects 24, and 2 or 3 select 32. Only the low W bits of a sample are sent, and slots outside the word are driven 0.
- R9: If the queue is empty when a frame's first pair is needed, the whole frame is sent as zeros rather than repeating the previous pair.
- R10: Each underflow produces a one-cycle `irq_urun` pulse when `urun_ie` is 1, and no pulse when it is 0.
- R11: `irq_fifo` is 1 when the queue holds 4 pairs or fewer (`empty_lvl`=0), or when it holds 0 pairs (`empty_lvl`=1).
- R12: While `tx_en` is 0, `sdata` and `frame_clk` are 0 and the queue keeps its contents and still accepts writes. After re-enable the next tick is slot 0 of a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Serializer enable; low holds the slot state at idle |
| bit_tick | input | 1 | One-cycle strobe per bit-clock period |
| delay_one | input | 1 | Delay the MSB by one slot |
| right_just | input | 1 | Right-justify the word within the half |
| word_len | input | 2 | Word length code (0:16, 1:24, 2/3:32) |
| empty_lvl | input | 1 | Queue interrupt threshold: 0 half-empty, 1 empty |
| urun_ie | input | 1 | Underflow interrupt enable |
| wr_left | input | 1 | Left sample write strobe |
| wr_right | input | 1 | Right sample write strobe; commits the pair |
| wdata | input | 32 | Sample write data |
| fifo_full | output | 1 | Queue holds 8 pairs |
| irq_fifo | output | 1 | Queue level interrupt |
| irq_urun | output | 1 | Underflow pulse |
| sdata | output | 1 | Serial data |
| frame_clk | output | 1 | Frame phase: 0 left, 1 right |

## Verification
A wrong slot counter or a misapplied framing offset shows up on `sdata` within the first tick of the affected half-frame. A one-bit shift in the stream would also move the `frame_clk` edge against the data within one frame. A broken queue pointer or count surfaces as a wrong pair in the next frame, or as `fifo_full` and `irq_fifo` disagreeing with the number of pairs written minus the frames started. An underflow that repeats stale data instead of zeros is visible over the whole frame that follows the empty queue.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    localparam int SAMPLE_W    = 32;
    localparam int HALF_SLOTS  = 32;
    localparam int FRAME_SLOTS = 2 * HALF_SLOTS;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);
    localparam int IDX_W       = $clog2(SAMPLE_W);

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    typedef enum logic [1:0] {
        WL_16   = 2'd0,
        WL_24   = 2'd1,
        WL_32   = 2'd2,
        WL_RSVD = 2'd3
    } wlen_e;

    typedef struct packed {
        logic  delay_one;
        logic  right_just;
        wlen_e wlen;
    } frame_cfg_t;

    function automatic int word_bits(wlen_e w);
        case (w)
            WL_16:   return 16;
            WL_24:   return 24;
            default: return 32;
        endcase
    endfunction

    // Bit carried by slot 'pos' of a half-frame for the given word.
    function automatic logic slot_bit(sample_t word, logic [SLOT_W-2:0] pos,
                                      frame_cfg_t cfg);
        int               nb;
        int               p;
        logic             hit;
        logic [IDX_W-1:0] idx;
        nb  = word_bits(cfg.wlen);
        p   = int'(pos);
        hit = 1'b0;
        idx = '0;
        if (!cfg.right_just) begin
            if (p < nb) begin
                hit = 1'b1;
                idx = IDX_W'(nb - 1 - p);
            end
        end else begin
            if (p >= HALF_SLOTS - nb) begin
                hit = 1'b1;
                idx = IDX_W'(HALF_SLOTS - 1 - p);
            end
        end
        return hit & word[idx];
    endfunction

endpackage

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo
    import aud_tx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_left,
    input  logic                         wr_right,
    input  sample_t                      wdata,
    input  logic                         pop,
    output pair_t                        head,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output logic                         full,
    output logic                         empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    pair_t          mem [DEPTH];
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  rd_ptr;
    sample_t        hold_l;
    logic           push;
    logic           take;

    assign full  = (fill == CW'(DEPTH));
    assign empty = (fill == '0);
    assign push  = wr_right && !full;
    assign take  = pop && !empty;
    assign head  = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= '{left: hold_l, right: wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            hold_l <= '0;
        end else begin
            if (wr_left) begin
                hold_l <= wdata;
            end
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (take) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push, take})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/aud_tx_shifter.sv
module aud_tx_shifter
    import aud_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  pair_t      head,
    input  logic       empty,
    output logic       pop,
    output logic       uflow,
    output logic       sdata,
    output logic       frame_clk
);

    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] lslot;
    logic              start;
    pair_t             cur;
    pair_t             live;
    sample_t           word;
    logic              nxt_bit;

    // Logical slot: physical slot minus the optional one-slot delay.
    assign lslot   = slot - SLOT_W'(cfg.delay_one);
    assign start   = (lslot == '0);
    assign live    = start ? (empty ? '0 : head) : cur;
    assign word    = lslot[SLOT_W-1] ? live.right : live.left;
    assign nxt_bit = slot_bit(word, lslot[SLOT_W-2:0], cfg);
    assign pop     = en && tick && start && !empty;
    assign uflow   = en && tick && start && empty;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            slot      <= '0;
            cur       <= '0;
            sdata     <= 1'b0;
            frame_clk <= 1'b0;
        end else if (tick) begin
            slot      <= slot + 1'b1;
            frame_clk <= slot[SLOT_W-1];
            sdata     <= nxt_bit;
            if (start) begin
                cur <= live;
            end
        end
    end

endmodule

// File: rtl/aud_tx_irq.sv
module aud_tx_irq #(
    parameter int DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(DEPTH+1)-1:0]  fill,
    input  logic                        empty_lvl,
    input  logic                        urun_ie,
    input  logic                        uflow,
    output logic                        irq_fifo,
    output logic                        irq_urun
);

    localparam int HALF = DEPTH / 2;

    assign irq_fifo = empty_lvl ? (fill == '0) : (int'(fill) <= HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_urun <= 1'b0;
        end else begin
            irq_urun <= uflow && urun_ie;
        end
    end

endmodule

// File: rtl/aud_tx_serializer.sv
module aud_tx_serializer
    import aud_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tx_en,
    input  logic        bit_tick,
    input  logic        delay_one,
    input  logic        right_just,
    input  logic [1:0]  word_len,
    input  logic        empty_lvl,
    input  logic        urun_ie,
    input  logic        wr_left,
    input  logic        wr_right,
    input  logic [31:0] wdata,
    output logic        fifo_full,
    output logic        irq_fifo,
    output logic        irq_urun,
    output logic        sdata,
    output logic        frame_clk
);

    localparam int CW = $clog2(FIFO_DEPTH + 1);

    frame_cfg_t     cfg;
    pair_t          head;
    logic [CW-1:0]  fill;
    logic           empty;
    logic           pop;
    logic           uflow;

    assign cfg = '{delay_one: delay_one, right_just: right_just,
                   wlen: wlen_e'(word_len)};

    aud_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_left  (wr_left),
        .wr_right (wr_right),
        .wdata    (sample_t'(wdata)),
        .pop      (pop),
        .head     (head),
        .fill     (fill),
        .full     (fifo_full),
        .empty    (empty)
    );

    aud_tx_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .en        (tx_en),
        .tick      (bit_tick),
        .cfg       (cfg),
        .head      (head),
        .empty     (empty),
        .pop       (pop),
        .uflow     (uflow),
        .sdata     (sdata),
        .frame_clk (frame_clk)
    );

    aud_tx_irq #(.DEPTH(FIFO_DEPTH)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .fill      (fill),
        .empty_lvl (empty_lvl),
        .urun_ie   (urun_ie),
        .uflow     (uflow),
        .irq_fifo  (irq_fifo),
        .irq_urun  (irq_urun)
    );

endmodule

// File: rtl/aud_tx_checker.sv
module aud_tx_checker #(
    parameter int DEPTH = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        tx_en,
    input logic                        bit_tick,
    input logic                        urun_ie,
    input logic                        sdata,
    input logic                        frame_clk,
    input logic                        irq_urun,
    input logic [$clog2(DEPTH+1)-1:0]  fill
);

    // R12: disabled serializer drives idle levels
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (sdata == 1'b0 && frame_clk == 1'b0));

    // R4: no tick while enabled means outputs hold
    p_slot_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !bit_tick) |=> ($stable(sdata) && $stable(frame_clk)));

    // R10: underflow pulse only when armed
    p_urun_armed_r10: assert property (@(posedge clk) disable iff (rst)
        irq_urun |-> $past(urun_ie));

    // R9: underflow pulse only follows an empty queue
    p_urun_empty_r9: assert property (@(posedge clk) disable iff (rst)
        irq_urun |-> ($past(fill) == '0));

    // R3: occupancy never exceeds the queue depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= DEPTH);

endmodule

bind aud_tx_serializer aud_tx_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .bit_tick  (bit_tick),
    .urun_ie   (urun_ie),
    .sdata     (sdata),
    .frame_clk (frame_clk),
    .irq_urun  (irq_urun),
    .fill      (fill)
);

// File: tb/aud_tx_serializer_tb.sv
module aud_tx_serializer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic        bit_tick = 1'b0;
    logic        delay_one = 1'b0;
    logic        right_just = 1'b0;
    logic [1:0]  word_len = 2'd0;
    logic        empty_lvl = 1'b0;
    logic        urun_ie = 1'b0;
    logic        wr_left = 1'b0;
    logic        wr_right = 1'b0;
    logic [31:0] wdata = '0;
    logic        fifo_full;
    logic        irq_fifo;
    logic        irq_urun;
    logic        sdata;
    logic        frame_clk;

    always #10 clk = ~clk;

    aud_tx_serializer u_dut (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .bit_tick   (bit_tick),
        .delay_one  (delay_one),
        .right_just (right_just),
        .word_len   (word_len),
        .empty_lvl  (empty_lvl),
        .urun_ie    (urun_ie),
        .wr_left    (wr_left),
        .wr_right   (wr_right),
        .wdata      (wdata),
        .fifo_full  (fifo_full),
        .irq_fifo   (irq_fifo),
        .irq_urun   (irq_urun),
        .sdata      (sdata),
        .frame_clk  (frame_clk)
    );

    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    bit [31:0]   ql[$];
    bit [31:0]   qr[$];
    bit [31:0]   hold_l = '0;
    bit [31:0]   cl = '0;
    bit [31:0]   cr = '0;
    int          slot_n = 0;
    bit          uf_frame = 1'b0;
    int          urun_seen = 0;
    int          urun_exp = 0;
    string       ctx = "";

    always @(negedge clk) begin
        if (irq_urun) urun_seen++;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (slot %0d)", tag, act, exp, slot_n);
        end
    endtask

    task automatic push_l(input bit [31:0] v);
        @(negedge clk);
        wr_left = 1'b1;
        wdata   = v;
        @(negedge clk);
        wr_left = 1'b0;
        hold_l  = v;
    endtask

    task automatic push_r(input bit [31:0] v);
        @(negedge clk);
        wr_right = 1'b1;
        wdata    = v;
        @(negedge clk);
        wr_right = 1'b0;
        if (ql.size() < 8) begin
            ql.push_back(hold_l);
            qr.push_back(v);
        end
    endtask

    function automatic bit exp_bit(input bit [31:0] w, input int pos);
        int nb;
        nb = (word_len == 2'd0) ? 16 : (word_len == 2'd1) ? 24 : 32;
        if (!right_just) return (pos < nb) ? w[nb-1-pos] : 1'b0;
        return (pos >= 32 - nb) ? w[31-pos] : 1'b0;
    endfunction

    task automatic tick_once();
        int    slot;
        int    q;
        bit    e;
        bit    lvl_exp;
        string tag;
        slot = slot_n % 64;
        if (slot == int'(delay_one)) begin
            if (ql.size() > 0) begin
                cl = ql.pop_front();
                cr = qr.pop_front();
                uf_frame = 1'b0;
            end else begin
                cl = '0;
                cr = '0;
                uf_frame = 1'b1;
                if (urun_ie) urun_exp++;
            end
        end
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        q = (slot - int'(delay_one) + 64) % 64;
        e = exp_bit((q >= 32) ? cr : cl, q % 32);
        if (ctx != "")          tag = ctx;
        else if (uf_frame)      tag = "R9";
        else if (right_just)    tag = "R7/R8";
        else if (delay_one)     tag = "R6/R8";
        else                    tag = "R5/R8";
        chk(sdata == e, tag, sdata, e);
        chk(frame_clk == (slot >= 32), "R4 frame_clk", frame_clk, slot >= 32);
        lvl_exp = empty_lvl ? (ql.size() == 0) : (ql.size() <= 4);
        chk(irq_fifo == lvl_exp, "R11 irq_fifo", irq_fifo, lvl_exp);
        chk(fifo_full == (ql.size() == 8), "R3 fifo_full", fifo_full, ql.size() == 8);
        slot_n++;
    endtask

    task automatic run_ticks(input int k);
        repeat (k) tick_once();
    endtask

    task automatic go_on();
        @(negedge clk);
        tx_en  = 1'b1;
        slot_n = 0;
        cl     = '0;
        cr     = '0;
    endtask

    task automatic go_off();
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(sdata == 1'b0, "R12 idle sdata", sdata, 0);
        chk(frame_clk == 1'b0, "R12 idle frame_clk", frame_clk, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(sdata == 1'b0, "R1 sdata", sdata, 0);
        chk(frame_clk == 1'b0, "R1 frame_clk", frame_clk, 0);
        chk(fifo_full == 1'b0, "R1 fifo_full", fifo_full, 0);
        chk(irq_fifo == 1'b1, "R1 irq_fifo", irq_fifo, 1);
        chk(irq_urun == 1'b0, "R1 irq_urun", irq_urun, 0);

        // Sweep every framing, justification and word-length code
        for (int c = 0; c < 16; c++) begin
            int s0;
            int e0;
            bit [31:0] base;
            go_off();
            delay_one  = c[3];
            right_just = c[2];
            word_len   = c[1:0];
            empty_lvl  = c[0];
            urun_ie    = c[1] ^ c[3];
            base = 32'h8000_0001 ^ (32'(c) * 32'h1357_9BDF);
            push_l(base);
            push_r(~base);
            push_l({base[15:0], base[31:16]});
            push_r(base ^ 32'h0F0F_F0F0);
            s0 = urun_seen;
            e0 = urun_exp;
            go_on();
            run_ticks(192);
            @(negedge clk);
            // R10: one pulse for the silent third frame when armed
            chk((urun_seen - s0) == (urun_exp - e0), "R10 urun count",
                urun_seen - s0, urun_exp - e0);
        end

        // R2 and R3: fill past depth, latest left wins, ninth pair dropped
        go_off();
        delay_one  = 1'b0;
        right_just = 1'b0;
        word_len   = 2'd2;
        empty_lvl  = 1'b0;
        urun_ie    = 1'b1;
        push_l(32'h1111_1111);
        push_l(32'hB0B0_0001);
        push_r(32'hC0C0_0002);
        for (int k = 1; k < 9; k++) begin
            push_l(32'hA000_0000 + 32'(k));
            push_r(32'h5000_0000 + 32'(k * 3));
        end
        @(negedge clk);
        chk(fifo_full == 1'b1, "R3 full after eight", fifo_full, 1);
        chk(irq_fifo == 1'b0, "R11 level above half", irq_fifo, 0);
        ctx = "R2";
        go_on();
        run_ticks(64);
        ctx = "";
        run_ticks(9 * 64);

        // R12: mid-frame disable, refill while off, clean restart
        go_off();
        delay_one = 1'b1;
        word_len  = 2'd1;
        push_l(32'h00F0_0F0F);
        push_r(32'h00AB_CDEF);
        go_on();
        run_ticks(37);
        go_off();
        push_l(32'h0055_AA33);
        push_r(32'h00CC_3355);
        chk(irq_fifo == 1'b1, "R12 queue kept", irq_fifo, 1);
        ctx = "R12";
        go_on();
        run_ticks(64);
        ctx = "";
        run_ticks(128);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule